// File: doc/BRIEF.md
# Elapsed-Time Clock with Reference Offset

This block keeps a running count of elapsed seconds, minutes and hours, driven by a one-cycle strobe that arrives once per second. It never stores the wall-clock time itself. Instead, the shown time is formed by adding an external reference start time to the elapsed count. Seconds and minutes add in base 60, and the hours wrap according to the configured 12-hour or 24-hour mode.

A small two-state sequencer runs on the same system clock. It lets the elapsed counters advance on the strobe cycle and loads the display register on the following cycle. The reference inputs are only read. A new reference value becomes visible at the next display load, which happens one cycle after a strobe, or in the first cycle after reset.

Top module: `offset_clock`

## Requirements
- R1: Each clock cycle with `tick` high advances the elapsed seconds by one. When the elapsed seconds would reach 60, they return to 0 and the elapsed minutes advance by one.
- R2: When the elapsed minutes would reach 60, they return to 0 and the elapsed hours advance by one.
- R3: The elapsed hours return to 0 when they would reach the hour limit. The limit is 24 when `HOURS_24`=1 and 12 when `HOURS_24`=0. For example, in 24-hour mode, 86400 ticks bring the elapsed time back to 0.
- R4: `disp_sec` = (`ref_sec` + elapsed seconds) mod 60. When that sum is 60 or more, a carry of 1 goes into the minutes sum.
- R5: `disp_min` = (`ref_min` + elapsed minutes + seconds carry) mod 60. When that sum is 60 or more, a carry of 1 goes into the hours sum.
- R6: In 24-hour mode, `disp_hr` = (`ref_hr` + elapsed hours + minutes carry) mod 24, which lies in 0..23. The legal `ref_hr` range is 0..23.
- R7: In 12-hour mode, `disp_hr` lies in 1..12. It equals h when h ≤ 12 and h−12 otherwise, where h = `ref_hr` + elapsed hours + minutes carry. The legal `ref_hr` range is 1..12.
- R8: The display outputs are registered. They load the sum on the clock edge that follows a `tick` edge, and they use the elapsed value after that tick and the reference value present at the load edge.
- R9: With no `tick`, the elapsed counters and the display outputs hold their values, even if the reference inputs change.
- R10: Synchronous reset clears the elapsed count and all display outputs to 0. The first clock edge after reset is released loads reference + 0 into the display.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle once-per-second strobe |
| ref_hr | input | 5 | Reference start hours |
| ref_min | input | 6 | Reference start minutes |
| ref_sec | input | 6 | Reference start seconds |
| disp_hr | output | 5 | Displayed hours |
| disp_min | output | 6 | Displayed minutes |
| disp_sec | output | 6 | Displayed seconds |

## Verification
The bench goes after the 59→0 seconds and minutes rollovers. A design that wrapped these at 100, or dropped the carry, would show 60 or would leave the minutes stuck. It also drives references that make the summed seconds and minutes cross 60 at the same moment. A design that added in base 100, or ignored the chained carry, would show the wrong minute or hour.

A full elapsed-hours wrap is checked in both modes side by side. A 12-hour design that shows 0, or a 24-hour design that reaches 24, is caught there. The bench changes the reference only while no tick is present, and it checks the display one cycle after each tick. A design that loaded the display every cycle, or one cycle late, would show the new reference too early or the old count too late.

// File: rtl/oc_pkg.sv
package oc_pkg;
  localparam int RADIX = 60;
  localparam int MS_W  = $clog2(RADIX);
  localparam int HR_W  = 5;

  typedef struct packed {
    logic [HR_W-1:0] hr;
    logic [MS_W-1:0] min;
    logic [MS_W-1:0] sec;
  } oc_time_t;

  typedef enum logic [0:0] {
    SEQ_IDLE   = 1'b0,
    SEQ_UPDATE = 1'b1
  } oc_seq_t;
endpackage

// File: rtl/oc_wrap_cnt.sv
module oc_wrap_cnt #(
  parameter int LIMIT = 60,
  parameter int W     = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         carry
);
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  assign carry = inc && (value == TOP);

  always_ff @(posedge clk) begin
    if (rst)        value <= '0;
    else if (carry) value <= '0;
    else if (inc)   value <= value + 1'b1;
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    value <= TOP);
  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(value));
  // R2
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && value == TOP) |=> value == '0);
endmodule

// File: rtl/oc_radix_add.sv
module oc_radix_add #(
  parameter int RADIX = 60,
  parameter int W     = 6
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam logic [W:0] RAD = (W+1)'(RADIX);
  logic [W:0] full;

  always_comb begin
    full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    cout = (full >= RAD);
    sum  = cout ? W'(full - RAD) : full[W-1:0];
  end

  // R4
  always_comb begin
    if ((a < W'(RADIX)) && (b < W'(RADIX)))
      sum_range_chk: assert (sum < W'(RADIX));
  end
endmodule

// File: rtl/oc_offset_add.sv
module oc_offset_add
  import oc_pkg::*;
#(
  parameter bit HOURS_24 = 1'b1
) (
  input  oc_time_t ref_t,
  input  oc_time_t ela_t,
  output oc_time_t sum_t
);
  logic            c_sec, c_min;
  logic [HR_W:0]   hsum;

  oc_radix_add #(.RADIX(RADIX), .W(MS_W)) u_sec (
    .a(ref_t.sec), .b(ela_t.sec), .cin(1'b0), .sum(sum_t.sec), .cout(c_sec)
  );
  oc_radix_add #(.RADIX(RADIX), .W(MS_W)) u_min (
    .a(ref_t.min), .b(ela_t.min), .cin(c_sec), .sum(sum_t.min), .cout(c_min)
  );

  assign hsum = {1'b0, ref_t.hr} + {1'b0, ela_t.hr} + {{HR_W{1'b0}}, c_min};

  generate
    if (HOURS_24) begin : g_h24
      always_comb
        sum_t.hr = (hsum >= (HR_W+1)'(24)) ? HR_W'(hsum - (HR_W+1)'(24)) : hsum[HR_W-1:0];
    end else begin : g_h12
      always_comb
        sum_t.hr = (hsum > (HR_W+1)'(12)) ? HR_W'(hsum - (HR_W+1)'(12)) : hsum[HR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/oc_sequencer.sv
module oc_sequencer
  import oc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic cnt_en,
  output logic out_en
);
  oc_seq_t state, state_nx;

  always_comb begin
    state_nx = tick ? SEQ_UPDATE : SEQ_IDLE;
    cnt_en   = tick;
    out_en   = (state == SEQ_UPDATE);
  end

  always_ff @(posedge clk) begin
    if (rst) state <= SEQ_UPDATE;
    else     state <= state_nx;
  end

  // R8
  seq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> out_en);
  // R9
  seq_rest_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> !out_en);
endmodule

// File: rtl/offset_clock.sv
module offset_clock
  import oc_pkg::*;
#(
  parameter bit HOURS_24 = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [4:0]      ref_hr,
  input  logic [5:0]      ref_min,
  input  logic [5:0]      ref_sec,
  output logic [4:0]      disp_hr,
  output logic [5:0]      disp_min,
  output logic [5:0]      disp_sec
);
  localparam int HR_LIMIT = HOURS_24 ? 24 : 12;

  logic     cnt_en, out_en;
  logic     c_sec, c_min, c_hr;
  oc_time_t ela_t, ref_t, sum_t, disp_q;

  oc_sequencer u_seq (
    .clk(clk), .rst(rst), .tick(tick), .cnt_en(cnt_en), .out_en(out_en)
  );

  oc_wrap_cnt #(.LIMIT(RADIX), .W(MS_W)) u_esec (
    .clk(clk), .rst(rst), .inc(cnt_en), .value(ela_t.sec), .carry(c_sec)
  );
  oc_wrap_cnt #(.LIMIT(RADIX), .W(MS_W)) u_emin (
    .clk(clk), .rst(rst), .inc(c_sec), .value(ela_t.min), .carry(c_min)
  );
  oc_wrap_cnt #(.LIMIT(HR_LIMIT), .W(HR_W)) u_ehr (
    .clk(clk), .rst(rst), .inc(c_min), .value(ela_t.hr), .carry(c_hr)
  );

  assign ref_t.hr  = ref_hr;
  assign ref_t.min = ref_min;
  assign ref_t.sec = ref_sec;

  oc_offset_add #(.HOURS_24(HOURS_24)) u_add (
    .ref_t(ref_t), .ela_t(ela_t), .sum_t(sum_t)
  );

  always_ff @(posedge clk) begin
    if (rst)         disp_q <= '0;
    else if (out_en) disp_q <= sum_t;
  end

  assign disp_hr  = disp_q.hr;
  assign disp_min = disp_q.min;
  assign disp_sec = disp_q.sec;

  // R9
  disp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> $stable(disp_q));
  // R6
  hr_range_chk: assert property (@(posedge clk) disable iff (rst)
    (out_en && ref_hr < 5'(HR_LIMIT) + 5'(!HOURS_24) && ref_min < 6'd60 && ref_sec < 6'd60)
    |=> (HOURS_24 ? (disp_hr < 5'd24) : (disp_hr >= 5'd1 && disp_hr <= 5'd12)));
  // R3
  hr_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    c_hr |=> ela_t.hr == '0);
endmodule

// File: tb/sim_offset_clock.sv
module sim_offset_clock;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [4:0] rh24 = '0, rh12 = 5'd12;
  logic [5:0] rmin = '0, rsec = '0;
  logic [4:0] h0, h1;
  logic [5:0] m0, m1, s0, s1;

  int errors = 0;
  int checks = 0;
  int ticks = 0;
  bit pend = 1'b1;
  bit done = 1'b0;
  int eh0 = 0, em0 = 0, es0 = 0, eh1 = 0, em1 = 0, es1 = 0;
  string phase = "R10";

  always #5 clk = ~clk;

  offset_clock #(.HOURS_24(1'b1)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .ref_hr(rh24), .ref_min(rmin), .ref_sec(rsec),
    .disp_hr(h0), .disp_min(m0), .disp_sec(s0)
  );
  offset_clock #(.HOURS_24(1'b0)) u1 (
    .clk(clk), .rst(rst), .tick(tick), .ref_hr(rh12), .ref_min(rmin), .ref_sec(rsec),
    .disp_hr(h1), .disp_min(m1), .disp_sec(s1)
  );

  function automatic void model(input int rh, input int rm, input int rs, input int t,
                                input bit m24, output int oh, output int om, output int os);
    int lim = m24 ? 24 : 12;
    int s = rs + t % 60;
    int m = rm + (t / 60) % 60 + (s >= 60 ? 1 : 0);
    int h = rh + (t / 3600) % lim + (m >= 60 ? 1 : 0);
    os = s % 60;
    om = m % 60;
    if (m24) oh = h % 24;
    else     oh = (h > 12) ? h - 12 : h;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (tick count %0d)", tag, what, act, exp, ticks);
    end
  endtask

  task automatic compare();
    chk(phase, "u0 sec", s0, es0);
    chk(phase, "u0 min", m0, em0);
    chk(phase, "u0 hr",  h0, eh0);
    chk(phase, "u1 sec", s1, es1);
    chk(phase, "u1 min", m1, em1);
    chk(phase, "u1 hr",  h1, eh1);
  endtask

  // Called at a negedge: drives inputs, predicts the next edge, checks after it.
  task automatic step(input bit tk);
    tick = tk;
    if (rst) begin
      ticks = 0; pend = 1'b1;
      eh0 = 0; em0 = 0; es0 = 0; eh1 = 0; em1 = 0; es1 = 0;
    end else begin
      if (pend) begin
        model(rh24, rmin, rsec, ticks, 1'b1, eh0, em0, es0);
        model(rh12, rmin, rsec, ticks, 1'b0, eh1, em1, es1);
      end
      if (tk) ticks++;
      pend = tk;
    end
    @(negedge clk);
    compare();
  endtask

  initial begin
    @(negedge clk);
    // R10: reset state and first load of the reference
    phase = "R10";
    for (int i = 0; i < 3; i++) step(1'b0);
    rst = 1'b0; rh24 = 5'd10; rh12 = 5'd5; rmin = 6'd20; rsec = 6'd30;
    step(1'b0);
    step(1'b0);
    // R9: no tick, reference changes must not reach the display
    phase = "R9";
    rh24 = 5'd3; rh12 = 5'd7; rmin = 6'd1; rsec = 6'd2;
    for (int i = 0; i < 5; i++) step(1'b0);
    // R1: seconds rollover with zero reference
    phase = "R1";
    rh24 = 5'd0; rh12 = 5'd12; rmin = 6'd0; rsec = 6'd0;
    for (int i = 0; i < 62; i++) step(1'b1);
    // R2: minutes rollover into hours
    phase = "R2";
    for (int i = 0; i < 3600; i++) step(1'b1);
    // R8: isolated ticks with reference changes between them
    phase = "R8";
    for (int i = 0; i < 20; i++) begin
      step(1'b1);
      rsec = 6'((i * 7) % 60); rmin = 6'((i * 11) % 60);
      rh24 = 5'(i % 24); rh12 = 5'(1 + i % 12);
      step(1'b0);
      step(1'b0);
    end
    // R4: seconds sum crossing 60
    phase = "R4";
    rsec = 6'd45; rmin = 6'd10; rh24 = 5'd4; rh12 = 5'd4;
    for (int i = 0; i < 130; i++) step(1'b1);
    // R5: seconds and minutes carries together into the hours
    phase = "R5";
    rsec = 6'd59; rmin = 6'd59; rh24 = 5'd22; rh12 = 5'd11;
    for (int i = 0; i < 3700; i++) step(1'b1);
    // R6: 24-hour wrap of the summed hours
    phase = "R6";
    rh24 = 5'd23; rh12 = 5'd12; rmin = 6'd30; rsec = 6'd40;
    for (int i = 0; i < 7300; i++) step(1'b1);
    // R7: 12-hour display range across a 12-hour span
    phase = "R7";
    rh24 = 5'd13; rh12 = 5'd12; rmin = 6'd58; rsec = 6'd50;
    for (int i = 0; i < 44000; i++) step(1'b1);
    // R3: full elapsed-hour wrap in both modes
    phase = "R3";
    rh24 = 5'd0; rh12 = 5'd1; rmin = 6'd0; rsec = 6'd0;
    for (int i = 0; i < 43500; i++) step(1'b1);
    step(1'b0);
    // R10: reset in mid-run clears everything
    phase = "R10";
    rst = 1'b1;
    step(1'b1);
    step(1'b0);
    rst = 1'b0;
    step(1'b0);
    step(1'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished (phase %s)", phase);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule